// File: doc/BRIEF.md
# Real-Time Clock Seconds Prescaler with Write-Aligned Start

This block turns a stream of oscillator strobes (nominally 32768 per second, each a one-cycle pulse in the system clock domain) into a one-cycle seconds pulse. The seconds pulse advances the timekeeping counters elsewhere in the chip. A software-controlled enable bit governs the whole path. While that bit is clear, the prescaler is parked at zero and nothing counts.

Counting starts only when a host transaction into the timing registers has finished, with the enable bit set. The bus decoder reports that event as a one-cycle completion strobe. Each accepted strobe resets the prescaler phase. As a result, every second, the first one included, is measured from the end of the most recent valid write. A strobe that arrives while the enable bit is clear is discarded.

Top module: `rtc_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `sec_tick` and `running` are 0.
- R2: If `wr_en` is 0 at a clock edge, `running` is 0 in the next cycle. No `sec_tick` pulse appears in the next cycle.
- R3: A `wr_done` strobe sampled while `wr_en` is 0 has no effect: `running` stays 0.
- R4: With `wr_en` at 1 but no accepted `wr_done` since `wr_en` was last 0, `running` stays 0 and `sec_tick` stays 0, whatever `osc_tick` does.
- R5: A `wr_done` sampled with `wr_en` at 1 sets `running` to 1 from the next cycle onward, for as long as `wr_en` stays 1.
- R6: After an accepted `wr_done`, the first `sec_tick` is high in the cycle after the DIV-th cycle with `osc_tick` at 1. That count starts with the cycle after the strobe. An `osc_tick` in the same cycle as the strobe is not counted.
- R7: While running, `sec_tick` repeats after every further DIV sampled `osc_tick` cycles, and each pulse lasts exactly one cycle.
- R8: An accepted `wr_done` while already running resets the phase. The count of R6 restarts, and `sec_tick` is 0 in the cycle after the strobe.
- R9: Only cycles with `osc_tick` at 1 advance the prescaler. Gaps of any length between oscillator strobes only stretch the second.
- R10: After `wr_en` returns to 1 following a clear, counting resumes only on a new accepted `wr_done`. The previous phase is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle strobe per oscillator period (nominally 32768 Hz) |
| wr_en | input | 1 | Software write/count enable bit; 0 holds the prescaler cleared |
| wr_done | input | 1 | One-cycle strobe: a valid timing-register write has just ended |
| sec_tick | output | 1 | One-cycle pulse once per DIV oscillator strobes |
| running | output | 1 | 1 while the prescaler is counting |

## Verification
The assertions assume that `osc_tick` and `wr_done` are already single-cycle strobes synchronous to `clk`. They also assume that DIV is at least 2, so a seconds pulse can never be followed directly by another one. The bench drives every input at the falling edge and changes each of them at most once per cycle. It mixes oscillator patterns (continuous, sparse, coincident with the completion strobe) and keeps all strobes synchronous, so these assumptions always hold. A shortened DIV keeps several full seconds within the run.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } run_state_e;

    typedef struct packed {
        logic clear;
        logic advance;
    } div_ctrl_t;

    function automatic logic hits_last(input int unsigned cnt, input int unsigned div);
        return cnt == div - 1;
    endfunction

endpackage

// File: rtl/rtc_run_ctrl.sv
module rtc_run_ctrl
    import rtc_pre_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      osc_tick,
    input  logic      wr_en,
    input  logic      wr_done,
    output div_ctrl_t ctrl,
    output logic      running
);

    run_state_e state_q, state_d;
    logic       keep_counting;

    always_comb begin
        state_d = state_q;
        if (!wr_en) begin
            state_d = ST_HALT;
        end else if (wr_done) begin
            state_d = ST_COUNT;
        end else if (state_q == ST_HALT) begin
            state_d = ST_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // counting continues only in COUNT, enabled, and not being realigned
    assign keep_counting = (state_q == ST_COUNT) && wr_en && !wr_done;

    always_comb begin
        ctrl.clear   = !keep_counting;
        ctrl.advance = keep_counting && osc_tick;
    end

    assign running = (state_q == ST_COUNT);

endmodule

// File: rtl/rtc_div_counter.sv
module rtc_div_counter
    import rtc_pre_pkg::*;
#(
    parameter int unsigned DIV = 32768,
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic      clk,
    input  logic      rst,
    input  div_ctrl_t ctrl,
    output logic      terminal
);

    logic [CW-1:0] count_q;
    logic          at_last;

    assign at_last  = hits_last(32'(count_q), DIV);
    assign terminal = ctrl.advance && at_last;

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            count_q <= '0;
        end else if (ctrl.advance) begin
            if (at_last) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_tick_reg.sv
module rtc_tick_reg (
    input  logic clk,
    input  logic rst,
    input  logic terminal,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= terminal;
        end
    end

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_pre_pkg::*;
#(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic wr_en,
    input  logic wr_done,
    output logic sec_tick,
    output logic running
);

    div_ctrl_t ctrl;
    logic      terminal;

    rtc_run_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .wr_en    (wr_en),
        .wr_done  (wr_done),
        .ctrl     (ctrl),
        .running  (running)
    );

    rtc_div_counter #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .terminal (terminal)
    );

    rtc_tick_reg u_tick (
        .clk      (clk),
        .rst      (rst),
        .terminal (terminal),
        .pulse    (sec_tick)
    );

endmodule

// File: rtl/rtc_tick_gen_chk.sv
module rtc_tick_gen_chk #(
    parameter int unsigned DIV = 32768,
    localparam int unsigned SW = $clog2(DIV) + 1
) (
    input logic clk,
    input logic rst,
    input logic osc_tick,
    input logic wr_en,
    input logic wr_done,
    input logic sec_tick,
    input logic running
);

    localparam logic [SW-1:0] DIV_V = SW'(DIV);

    logic [SW-1:0] seen_q;
    logic [SW-1:0] base;

    assign base = sec_tick ? '0 : seen_q;

    always_ff @(posedge clk) begin
        if (rst || !wr_en || wr_done) begin
            seen_q <= '0;
        end else if (running && osc_tick) begin
            seen_q <= base + 1'b1;
        end else begin
            seen_q <= base;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!sec_tick && !running));

    // R2
    disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!running && !sec_tick));

    // R4
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> running);

    // R5
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_done) |=> running);

    // R8
    realign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !sec_tick);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (seen_q == DIV_V));

    // R9
    no_missed_tick_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q <= DIV_V);

endmodule

bind rtc_tick_gen rtc_tick_gen_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .wr_en    (wr_en),
    .wr_done  (wr_done),
    .sec_tick (sec_tick),
    .running  (running)
);

// File: tb/rtc_tick_gen_test.sv
`timescale 1ns/1ps
module rtc_tick_gen_test;

    localparam int unsigned TB_DIV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic wr_en = 1'b0;
    logic wr_done = 1'b0;
    logic sec_tick;
    logic running;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  tick;
        logic  run;
        string tag;
    } exp_t;

    exp_t sb[$];

    // model state from requirements
    logic        m_run = 1'b0;
    int unsigned m_cnt = 0;

    always #2.5 clk = ~clk;

    rtc_tick_gen #(.DIV(TB_DIV)) uut (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .wr_en    (wr_en),
        .wr_done  (wr_done),
        .sec_tick (sec_tick),
        .running  (running)
    );

    task automatic step(input logic osc, input logic en, input logic done, input string tag);
        exp_t e;
        @(negedge clk);
        osc_tick = osc;
        wr_en    = en;
        wr_done  = done;
        e.tick = 1'b0;
        if (!en) begin
            m_run = 1'b0;
            m_cnt = 0;
        end else if (done) begin
            m_run = 1'b1;
            m_cnt = 0;
        end else if (m_run && osc) begin
            if (m_cnt == TB_DIV - 1) begin
                m_cnt  = 0;
                e.tick = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        e.run = m_run;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (sec_tick !== e.tick || running !== e.run) begin
                    failures++;
                    $display("FAIL %s: sec_tick=%b running=%b expected sec_tick=%b running=%b",
                             e.tag, sec_tick, running, e.tick, e.run);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1.5;
        // R1: state right after reset
        checks++;
        if (sec_tick !== 1'b0 || running !== 1'b0) begin
            failures++;
            $display("FAIL R1: sec_tick=%b running=%b expected 0 0", sec_tick, running);
        end
        step(1'b0, 1'b0, 1'b0, "R1");

        // R3: strobes with enable clear are ignored
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, (i % 2) == 0, "R3");

        // R4: enabled, no write yet
        for (int i = 0; i < 3 * TB_DIV; i++) step(1'b1, 1'b1, 1'b0, "R4");

        // R5/R6: strobe coincident with an oscillator tick
        step(1'b1, 1'b1, 1'b1, "R5");
        for (int i = 0; i < TB_DIV + 1; i++) step(1'b1, 1'b1, 1'b0, "R6");

        // R7: continuous seconds
        for (int i = 0; i < 3 * TB_DIV; i++) step(1'b1, 1'b1, 1'b0, "R7");

        // R9: sparse oscillator strobes
        for (int i = 0; i < 6 * TB_DIV; i++) step((i % 3) == 0, 1'b1, 1'b0, "R9");

        // R8: realignment mid-second and right at a terminal count
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        for (int i = 0; i < TB_DIV - 1; i++) step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 2 * TB_DIV + 2; i++) step(1'b1, 1'b1, 1'b0, "R8");

        // R2: enable dropped while running, strobes present
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 2 * TB_DIV; i++) step(1'b1, 1'b0, (i % 4) == 1, "R2");

        // R10: re-enable without a write, then resume on a write
        for (int i = 0; i < 2 * TB_DIV; i++) step(1'b1, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        for (int i = 0; i < 2 * TB_DIV + 3; i++) step((i % 2) == 0, 1'b1, 1'b0, "R10");

        step(1'b0, 1'b1, 1'b0, "R7");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule